// File: doc/BRIEF.md
# Shared Interrupt Line Aggregator

This block gathers the level-sensitive interrupt pins of a set of device slots and merges them onto a few shared bus interrupt lines. Every slot has four pins. A fixed swizzle routes each pin to one bus line. The swizzle also applies one extra rotation for every bridge level that sits between the slots and the bus that drives the physical lines.

The block does not OR all sources together every cycle. It keeps the last level it has seen on every pin, and it holds one counter per bus line. That counter is the number of asserted pins routed to the line. When a pin changes, its line's counter steps up on a rise or down on a fall. A line output is high whenever its counter is non-zero.

The pending set is the difference between the live pins and the stored levels. It acts as the work queue. One change is taken per cycle, lowest source index first. The counters and the stored levels can be read out and loaded back, for example to save and restore state. A load whose line count does not match the build is refused.

Top module: `irq_share_agg`

## Requirements
- R1: Pin p (0 to 3) of slot s is routed to line (p + s + B) mod NUM_LINES. B is the sum of the slot numbers of the bridge levels: entry k is BRIDGE_SLOTS[8k+7:8k], and each level adds its entry. The default is two levels, with slots 1 and 2.
- R2: A pin whose live level equals its stored level causes no change: with steady pins, cnt_out, lvl_out and irq_line hold their values.
- R3: A rise of a pin increments its line's counter and a fall decrements it. A single change appears in cnt_out, lvl_out and irq_line after the first rising clock edge that sees it.
- R4: irq_line[i] is high exactly when counter i is non-zero. Once the block has settled, this equals the OR of the pins routed to line i.
- R5: When several pins differ from their stored levels, one is handled per cycle, in ascending order of the source index slot*4+pin.
- R6: cnt_out carries counter i in bits [i*CNT_W +: CNT_W], where CNT_W = ceil(log2(NUM_SLOTS*4+1)). lvl_out carries the stored level of source slot*4+pin in that bit.
- R7: A load request with rs_lines equal to NUM_LINES replaces all counters with rs_cnt and all stored levels with rs_lvl at that clock edge. irq_line follows at the same edge, and no pin change is handled in that cycle.
- R8: A load request with any other rs_lines changes no state. rs_reject is high for exactly the one cycle after the request, and no pin change is handled in the request cycle.
- R9: A fall routed to a counter at 0, or a rise routed to a counter equal to NUM_SLOTS*4, leaves that counter unchanged. It still records the new pin level and sets err, which stays high until reset.
- R10: Reset (synchronous, active high) clears all stored levels, counters, irq_line, err and rs_reject.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_lvl | input | NUM_SLOTS*4 | Live pin levels, bit slot*4+pin |
| rs_valid | input | 1 | Load (restore) request, one cycle |
| rs_lines | input | RS_W | Line count claimed by the load image |
| rs_cnt | input | NUM_LINES*CNT_W | Counter image to load |
| rs_lvl | input | NUM_SLOTS*4 | Stored-level image to load |
| irq_line | output | NUM_LINES | Shared bus interrupt lines |
| cnt_out | output | NUM_LINES*CNT_W | Per-line counters for readback |
| lvl_out | output | NUM_SLOTS*4 | Stored pin levels for readback |
| err | output | 1 | Sticky counter underflow/overflow flag |
| rs_reject | output | 1 | One-cycle pulse after a refused load |

## Verification
Two pins on the same line rise together, then fall one at a time. This separates handling in order, one change per cycle, from batch handling. It also shows that the line stays up while any source remains. Random 32-bit pin vectors, each allowed to settle, compare every counter and line with a count taken over the routing formula; this catches swizzle or bridge-offset mistakes that directed cases can miss. Load images are driven with a wrong line count and with the right one, and a pin toggles in the same cycle. Loaded images that are out of step with the pins are used to force underflow and overflow, which shows the counters saturating and err staying set.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int PINS_PER_SLOT = 4;

  function automatic int wrap_add(input int a, input int b, input int m);
    return (a + b) % m;
  endfunction
endpackage

// File: rtl/irq_agg_pick.sv
// Lowest-index selector over the pending-change vector.
module irq_agg_pick #(
  parameter int N = 32,
  parameter int W = 5
) (
  input  logic [N-1:0] req,
  output logic         hit,
  output logic [W-1:0] idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        hit = 1'b1;
        idx = W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_agg_route.sv
// Swizzle: slot rotation on the local bus, then one rotation per bridge level.
module irq_agg_route #(
  parameter int                      NUM_LINES    = 4,
  parameter int                      BRIDGE_DEPTH = 2,
  parameter logic [BRIDGE_DEPTH*8-1:0] BRIDGE_SLOTS = {8'd2, 8'd1},
  parameter int                      IDX_W        = 5,
  parameter int                      LINE_W       = 2
) (
  input  logic [IDX_W-1:0]  src_idx,
  output logic [LINE_W-1:0] line_idx
);
  import irq_agg_pkg::*;

  logic [LINE_W-1:0] hop [BRIDGE_DEPTH+1];

  assign hop[0] = LINE_W'(wrap_add(int'(src_idx[1:0]), int'(src_idx >> 2), NUM_LINES));

  for (genvar k = 0; k < BRIDGE_DEPTH; k++) begin : g_hop
    assign hop[k+1] = LINE_W'(wrap_add(int'(hop[k]), int'(BRIDGE_SLOTS[k*8 +: 8]), NUM_LINES));
  end

  assign line_idx = hop[BRIDGE_DEPTH];
endmodule

// File: rtl/irq_agg_count.sv
// Per-line source counters, registered line drive and sticky error.
module irq_agg_count #(
  parameter int NUM_LINES = 4,
  parameter int CNT_W     = 6,
  parameter int MAX_CNT   = 32,
  parameter int LINE_W    = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       step,
  input  logic [LINE_W-1:0]          step_line,
  input  logic                       step_up,
  input  logic                       load,
  input  logic [NUM_LINES*CNT_W-1:0] load_cnt,
  output logic [NUM_LINES*CNT_W-1:0] cnt_q,
  output logic [NUM_LINES-1:0]       line_q,
  output logic                       err_q
);
  logic [NUM_LINES*CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0]           cur;
  logic                       bad;

  always_comb begin
    cnt_d = cnt_q;
    bad   = 1'b0;
    cur   = cnt_q[step_line*CNT_W +: CNT_W];
    if (load) begin
      cnt_d = load_cnt;
    end else if (step) begin
      if (step_up) begin
        if (cur == CNT_W'(MAX_CNT)) bad = 1'b1;
        else cnt_d[step_line*CNT_W +: CNT_W] = cur + 1'b1;
      end else begin
        if (cur == '0) bad = 1'b1;
        else cnt_d[step_line*CNT_W +: CNT_W] = cur - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      line_q <= '0;
      err_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      err_q <= err_q | bad;
      for (int i = 0; i < NUM_LINES; i++) line_q[i] <= |cnt_d[i*CNT_W +: CNT_W];
    end
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst) $past(err_q) |-> err_q); // R9

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_chk
    AST_LINE_TRACKS_CNT: assert property (@(posedge clk) disable iff (rst)
      line_q[i] == (cnt_q[i*CNT_W +: CNT_W] != '0)); // R4
    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
      !$past(load) |-> (cnt_q[i*CNT_W +: CNT_W] == $past(cnt_q[i*CNT_W +: CNT_W]) ||
                        cnt_q[i*CNT_W +: CNT_W] == $past(cnt_q[i*CNT_W +: CNT_W]) + 1'b1 ||
                        cnt_q[i*CNT_W +: CNT_W] + 1'b1 == $past(cnt_q[i*CNT_W +: CNT_W]))); // R3
  end
endmodule

// File: rtl/irq_share_agg.sv
module irq_share_agg #(
  parameter int                        NUM_SLOTS    = 8,
  parameter int                        NUM_LINES    = 4,
  parameter int                        BRIDGE_DEPTH = 2,
  parameter logic [BRIDGE_DEPTH*8-1:0] BRIDGE_SLOTS = {8'd2, 8'd1},
  parameter int                        RS_W         = 8,
  localparam int NUM_SRC = NUM_SLOTS * irq_agg_pkg::PINS_PER_SLOT,
  localparam int CNT_W   = $clog2(NUM_SRC + 1)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_SRC-1:0]         pin_lvl,
  input  logic                       rs_valid,
  input  logic [RS_W-1:0]            rs_lines,
  input  logic [NUM_LINES*CNT_W-1:0] rs_cnt,
  input  logic [NUM_SRC-1:0]         rs_lvl,
  output logic [NUM_LINES-1:0]       irq_line,
  output logic [NUM_LINES*CNT_W-1:0] cnt_out,
  output logic [NUM_SRC-1:0]         lvl_out,
  output logic                       err,
  output logic                       rs_reject
);
  localparam int IDX_W  = $clog2(NUM_SRC);
  localparam int LINE_W = $clog2(NUM_LINES);

  logic [NUM_SRC-1:0] lvl_q;
  logic [NUM_SRC-1:0] pending;
  logic               hit;
  logic [IDX_W-1:0]   idx;
  logic [LINE_W-1:0]  line_idx;
  logic               accept;
  logic               step;
  logic               rej_q;

  assign pending = pin_lvl ^ lvl_q;
  assign accept  = rs_valid && (rs_lines == RS_W'(NUM_LINES));
  assign step    = hit && !rs_valid;

  irq_agg_pick #(.N(NUM_SRC), .W(IDX_W)) u_pick (
    .req(pending), .hit(hit), .idx(idx)
  );

  irq_agg_route #(
    .NUM_LINES(NUM_LINES), .BRIDGE_DEPTH(BRIDGE_DEPTH), .BRIDGE_SLOTS(BRIDGE_SLOTS),
    .IDX_W(IDX_W), .LINE_W(LINE_W)
  ) u_route (
    .src_idx(idx), .line_idx(line_idx)
  );

  irq_agg_count #(
    .NUM_LINES(NUM_LINES), .CNT_W(CNT_W), .MAX_CNT(NUM_SRC), .LINE_W(LINE_W)
  ) u_count (
    .clk(clk), .rst(rst), .step(step), .step_line(line_idx), .step_up(pin_lvl[idx]),
    .load(accept), .load_cnt(rs_cnt), .cnt_q(cnt_out), .line_q(irq_line), .err_q(err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= '0;
      rej_q <= 1'b0;
    end else begin
      rej_q <= rs_valid && !accept;
      if (accept) lvl_q <= rs_lvl;
      else if (step) lvl_q[idx] <= pin_lvl[idx];
    end
  end

  assign lvl_out   = lvl_q;
  assign rs_reject = rej_q;

  AST_ONE_PIN_PER_CYCLE: assert property (@(posedge clk) disable iff (rst)
    !$past(rs_valid) |-> ($countones(lvl_q ^ $past(lvl_q)) <= 1)); // R5
  AST_REJECT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    rs_reject |-> ($stable(cnt_out) && $stable(lvl_q))); // R8
  AST_REJECT_PULSE: assert property (@(posedge clk) disable iff (rst)
    rs_reject |=> !rs_reject || $past(rs_valid)); // R8
endmodule

// File: tb/irq_share_agg_tb.sv
module irq_share_agg_tb;
  localparam int NSLOT = 8;
  localparam int NL    = 4;
  localparam int NS    = NSLOT * 4;
  localparam int CW    = $clog2(NS + 1);

  logic             clk = 1'b0;
  logic             rst;
  logic [NS-1:0]    pin_lvl;
  logic             rs_valid;
  logic [7:0]       rs_lines;
  logic [NL*CW-1:0] rs_cnt;
  logic [NS-1:0]    rs_lvl;
  logic [NL-1:0]    irq_line;
  logic [NL*CW-1:0] cnt_out;
  logic [NS-1:0]    lvl_out;
  logic             err;
  logic             rs_reject;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  irq_share_agg u_dut (
    .clk(clk), .rst(rst), .pin_lvl(pin_lvl), .rs_valid(rs_valid), .rs_lines(rs_lines),
    .rs_cnt(rs_cnt), .rs_lvl(rs_lvl), .irq_line(irq_line), .cnt_out(cnt_out),
    .lvl_out(lvl_out), .err(err), .rs_reject(rs_reject)
  );

  // routing per the requirement: bridge slots 1 and 2 add 3
  function automatic int map_line(input int src);
    return ((src % 4) + (src / 4) + 1 + 2) % NL;
  endfunction

  function automatic int exp_cnt(input logic [NS-1:0] v, input int line);
    int n = 0;
    for (int s = 0; s < NS; s++) if (v[s] && map_line(s) == line) n++;
    return n;
  endfunction

  function automatic int cnt_of(input int line);
    return int'(cnt_out[line*CW +: CW]);
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (NS + 2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; pin_lvl = '0; rs_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic check_model(input string tag);
    for (int l = 0; l < NL; l++) begin
      check(cnt_of(l) == exp_cnt(pin_lvl, l), {tag, " R1 counter"}, cnt_of(l), exp_cnt(pin_lvl, l));
      check(irq_line[l] == (exp_cnt(pin_lvl, l) != 0), {tag, " R4 line"}, irq_line[l], exp_cnt(pin_lvl, l) != 0);
    end
    check(lvl_out == pin_lvl, {tag, " R6 levels"}, lvl_out, pin_lvl);
  endtask

  initial begin
    logic [NL*CW-1:0] snap;
    logic [NS-1:0]    v;
    void'($urandom(32'd1234));
    rst = 1'b1; pin_lvl = '0; rs_valid = 1'b0; rs_lines = '0; rs_cnt = '0; rs_lvl = '0;
    repeat (3) @(negedge clk);
    check(cnt_out == '0 && irq_line == '0 && lvl_out == '0 && !err && !rs_reject,
          "R10 reset state", {cnt_out, irq_line}, 0);
    rst = 1'b0;

    // R5 / R3: two pins on line 1 rise in the same cycle
    @(negedge clk);
    pin_lvl = NS'(32'h24);
    @(negedge clk);
    check(lvl_out == NS'(32'h4), "R5 lowest first", lvl_out, 32'h4);
    check(cnt_of(1) == 1 && irq_line[1], "R3 one-edge latency", cnt_of(1), 1);
    @(negedge clk);
    check(lvl_out == NS'(32'h24), "R5 second change", lvl_out, 32'h24);
    check(cnt_of(1) == 2, "R3 increment", cnt_of(1), 2);
    pin_lvl = NS'(32'h20);
    @(negedge clk);
    check(cnt_of(1) == 1 && irq_line[1], "R4 line held by other source", cnt_of(1), 1);
    pin_lvl = '0;
    @(negedge clk);
    check(cnt_of(1) == 0 && !irq_line[1], "R3 decrement to zero", cnt_of(1), 0);

    // random patterns
    for (int r = 0; r < 30; r++) begin
      pin_lvl = NS'($urandom());
      settle();
      check_model("random");
      snap = cnt_out;
      repeat (5) @(negedge clk);
      check(cnt_out == snap && lvl_out == pin_lvl, "R2 steady pins", cnt_out, snap);
    end
    check(!err, "R9 no error in normal use", err, 0);

    // R8: wrong line count, with a pin toggle in the same cycle
    v = pin_lvl;
    snap = cnt_out;
    rs_valid = 1'b1; rs_lines = 8'd3; rs_cnt = '1; rs_lvl = ~v;
    pin_lvl = v ^ NS'(1);
    @(negedge clk);
    rs_valid = 1'b0;
    check(rs_reject, "R8 reject pulse", rs_reject, 1);
    check(cnt_out == snap && lvl_out == v, "R8 state unchanged", cnt_out, snap);
    @(negedge clk);
    check(!rs_reject, "R8 pulse one cycle", rs_reject, 0);
    check(lvl_out == pin_lvl, "R8 pin handled after", lvl_out, pin_lvl);

    // R7: accepted load
    settle();
    rs_valid = 1'b1; rs_lines = 8'd4; rs_lvl = pin_lvl;
    rs_cnt = {CW'(8), CW'(7), CW'(0), CW'(5)};
    @(negedge clk);
    rs_valid = 1'b0;
    check(cnt_out == {CW'(8), CW'(7), CW'(0), CW'(5)}, "R7 counters loaded", cnt_out, 0);
    check(irq_line == 4'b1101, "R7 lines follow", irq_line, 4'b1101);
    check(lvl_out == pin_lvl, "R7 levels loaded", lvl_out, pin_lvl);
    repeat (4) @(negedge clk);
    check(cnt_out == {CW'(8), CW'(7), CW'(0), CW'(5)}, "R2 no drift after load", cnt_out, 0);

    // R9 underflow
    do_reset();
    @(negedge clk);
    check(cnt_out == '0 && lvl_out == '0 && !err, "R10 second reset", cnt_out, 0);
    rs_valid = 1'b1; rs_lines = 8'd4; rs_cnt = '0; rs_lvl = NS'(1);
    @(negedge clk);
    rs_valid = 1'b0;
    check(lvl_out == NS'(1) && !err, "R7 level image", lvl_out, 1);
    @(negedge clk);
    check(err, "R9 underflow flag", err, 1);
    check(cnt_of(3) == 0 && lvl_out == '0, "R9 underflow holds counter", cnt_of(3), 0);
    for (int r = 0; r < 3; r++) begin
      pin_lvl = NS'($urandom());
      settle();
      check_model("after underflow");
      check(err, "R9 err sticky", err, 1);
    end

    // R9 overflow
    do_reset();
    rs_valid = 1'b1; rs_lines = 8'd4; rs_lvl = '0;
    rs_cnt = '0; rs_cnt[1*CW +: CW] = CW'(NS);
    @(negedge clk);
    rs_valid = 1'b0;
    pin_lvl = NS'(32'h4);
    @(negedge clk);
    check(err, "R9 overflow flag", err, 1);
    check(cnt_of(1) == NS && irq_line[1], "R9 overflow holds counter", cnt_of(1), NS);
    check(lvl_out == NS'(32'h4), "R9 level recorded", lvl_out, 32'h4);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog R10 actual=timeout expected=completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule